// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Tick Generation

This block is a 16-bit up-counter paired with a 16-bit holding register. Three control inputs choose one of three behaviours. In reload mode, the counter reloads from the holding register when it overflows. In capture mode, the counter wraps to zero and the holding register records the count when the trigger pin falls. In baud mode, overflows become clock ticks for a serial transmitter and receiver, and the counter reloads from the holding register.

Counting advances either on a divided internal clock or on falling edges of an external count pin. The internal divider is 12 in reload and capture modes and 2 in baud mode. A separate trigger pin is synchronised, and its falling edge can capture, reload, or only raise an event flag, depending on the mode. The overflow flag and the event flag stay set until a clear pulse removes them.

Top module: `capreload_timer`

## Requirements
- R1: After reset, the count, the holding register, both flags and both baud ticks read 0.
- R2: With `src_ext`=0 and `run_en`=1, the count advances by one every 12 clock cycles outside baud mode and every 2 clock cycles in baud mode. The divider restarts from zero while `run_en` is 0.
- R3: With `src_ext`=1 and `run_en`=1, each high-to-low transition of `count_pin` advances the count by one. The new value is visible after the third rising clock edge following the pin change.
- R4: With `run_en`=0, the count holds its value unless a trigger reload or a software write occurs.
- R5: In reload mode (both baud selects 0, `cap_mode`=0), a count step from 0xFFFF loads the holding register value and sets `ovf_flag`.
- R6: In capture mode (both baud selects 0, `cap_mode`=1), a count step from 0xFFFF wraps to 0x0000 and sets `ovf_flag`.
- R7: In capture mode, a falling edge on `trig_pin` with `trig_en`=1 copies the current count into the holding register. The count keeps its value and continues counting.
- R8: In reload mode, a falling edge on `trig_pin` with `trig_en`=1 loads the count from the holding register.
- R9: With `trig_en`=0, a falling edge on `trig_pin` has no effect: there is no capture, no reload and no event flag.
- R10: A falling edge on `trig_pin` with `trig_en`=1 sets `ext_flag` in every mode, three rising edges after the pin change.
- R11: When either baud select is 1, the block is in baud mode and `cap_mode` is ignored. In this mode:
  - an overflow reloads the count and does not set `ovf_flag`;
  - an overflow pulses `tx_tick` and/or `rx_tick` for one cycle, according to the selects;
  - a trigger edge neither captures nor reloads.
- R12: `ovf_flag` and `ext_flag` stay set until `ovf_clr` or `ext_clr` is pulsed. The pulse clears the flag at the next rising edge.
- R13: `cnt_wr` and `hold_wr` load their data at the next rising edge and take priority over counting, capture and reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable |
| src_ext | input | 1 | 1: count on `count_pin` falls; 0: internal divider |
| cap_mode | input | 1 | 1: capture, 0: reload (ignored in baud mode) |
| rx_baud_sel | input | 1 | Route overflow to receive tick (baud mode) |
| tx_baud_sel | input | 1 | Route overflow to transmit tick (baud mode) |
| trig_en | input | 1 | Enable trigger pin |
| count_pin | input | 1 | External count input |
| trig_pin | input | 1 | External trigger input |
| cnt_wr | input | 1 | Write strobe for the count |
| cnt_wdata | input | 16 | Count write data |
| hold_wr | input | 1 | Write strobe for the holding register |
| hold_wdata | input | 16 | Holding register write data |
| ovf_clr | input | 1 | Clear overflow flag |
| ext_clr | input | 1 | Clear event flag |
| count | output | 16 | Current count |
| hold | output | 16 | Holding (capture/reload) register |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | Trigger event flag |
| tx_tick | output | 1 | Transmit baud tick |
| rx_tick | output | 1 | Receive baud tick |

## Verification
Each result has its own latency:
- A software write or a flag clear shows one rising edge later.
- A pin fall affects the count, the holding register or `ext_flag` exactly three rising edges after the pin changes.
- Internally clocked counts arrive every 12 or 2 edges once the divider restarts.
- A baud tick is high only in the cycle right after the reload edge.

The bench drives every input on the falling clock edge and samples on a later falling edge, counted from the stimulus. Around each pin change it checks that the output has not moved one edge early and that it has moved at the due edge.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
package crt_pkg;
  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_BAUD    = 2'd2
  } crt_mode_e;

  function automatic crt_mode_e crt_decode(input logic rx_sel,
                                           input logic tx_sel,
                                           input logic cap_sel);
    if (rx_sel || tx_sel) return MODE_BAUD;
    else if (cap_sel)     return MODE_CAPTURE;
    else                  return MODE_RELOAD;
  endfunction
endpackage

// File: rtl/crt_edge_sync.sv
`timescale 1ns/1ps
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  assign sync_d[0] = pin;
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    assign sync_d[g] = sync_q[g-1];
  end

  assign last_d = sync_q[STAGES-1];
  assign fall   = last_q & ~sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/crt_prescale.sv
`timescale 1ns/1ps
module crt_prescale #(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW     = $clog2(MAXDIV + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic [PW-1:0] limit;

  assign limit = fast ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
  assign tick  = run && (pre_q == limit);

  always_comb begin
    if (!run || (pre_q >= limit)) pre_d = '0;
    else                          pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));
endmodule

// File: rtl/crt_core.sv
`timescale 1ns/1ps
module crt_core
  import crt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  crt_mode_e    mode,
  input  logic         tick,
  input  logic         trig_fall,
  input  logic         trig_en,
  input  logic         tx_sel,
  input  logic         rx_sel,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         hold_wr,
  input  logic [W-1:0] hold_wdata,
  input  logic         ovf_clr,
  input  logic         ext_clr,
  output logic [W-1:0] count_q,
  output logic [W-1:0] hold_q,
  output logic         ovf_q,
  output logic         ext_q,
  output logic         tx_q,
  output logic         rx_q
);
  logic [W-1:0] count_d;
  logic [W-1:0] hold_d;
  logic         ovf_d;
  logic         ext_d;
  logic         tx_d;
  logic         rx_d;
  logic         wrap;
  logic         trig_hit;
  logic         is_baud;

  assign wrap     = tick && (count_q == {W{1'b1}});
  assign trig_hit = trig_fall && trig_en;
  assign is_baud  = (mode == MODE_BAUD);

  always_comb begin
    count_d = count_q;
    if (cnt_wr)                                 count_d = cnt_wdata;
    else if (trig_hit && mode == MODE_RELOAD)   count_d = hold_q;
    else if (wrap)                              count_d = (mode == MODE_CAPTURE) ? '0 : hold_q;
    else if (tick)                              count_d = count_q + 1'b1;

    hold_d = hold_q;
    if (hold_wr)                                hold_d = hold_wdata;
    else if (trig_hit && mode == MODE_CAPTURE)  hold_d = count_q;

    ovf_d = (ovf_q && !ovf_clr) || (wrap && !is_baud);
    ext_d = (ext_q && !ext_clr) || trig_hit;
    tx_d  = wrap && is_baud && tx_sel;
    rx_d  = wrap && is_baud && rx_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      hold_q  <= '0;
      ovf_q   <= 1'b0;
      ext_q   <= 1'b0;
      tx_q    <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      hold_q  <= hold_d;
      ovf_q   <= ovf_d;
      ext_q   <= ext_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
    end
  end

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr && !trig_hit) |=> (count_q == $past(count_q)));
  // R5
  reload_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RELOAD && wrap && !cnt_wr && !trig_hit) |=> (count_q == $past(hold_q) && ovf_q));
  // R7
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CAPTURE && trig_hit && !hold_wr) |=> (hold_q == $past(count_q)));
  // R10
  ext_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> ext_q);
  // R11
  baud_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_baud && !ovf_q) |=> !ovf_q);
  // R12
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: rtl/capreload_timer.sv
`timescale 1ns/1ps
module capreload_timer
  import crt_pkg::*;
#(
  parameter int W           = 16,
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         src_ext,
  input  logic         cap_mode,
  input  logic         rx_baud_sel,
  input  logic         tx_baud_sel,
  input  logic         trig_en,
  input  logic         count_pin,
  input  logic         trig_pin,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         hold_wr,
  input  logic [W-1:0] hold_wdata,
  input  logic         ovf_clr,
  input  logic         ext_clr,
  output logic [W-1:0] count,
  output logic [W-1:0] hold,
  output logic         ovf_flag,
  output logic         ext_flag,
  output logic         tx_tick,
  output logic         rx_tick
);
  crt_mode_e mode;
  logic      pre_tick;
  logic      pin_fall;
  logic      trig_fall;
  logic      step;

  assign mode = crt_decode(rx_baud_sel, tx_baud_sel, cap_mode);
  assign step = src_ext ? (run_en && pin_fall) : pre_tick;

  crt_prescale #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_en && !src_ext),
    .fast(mode == MODE_BAUD), .tick(pre_tick)
  );

  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .pin(count_pin), .fall(pin_fall)
  );

  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .pin(trig_pin), .fall(trig_fall)
  );

  crt_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(step),
    .trig_fall(trig_fall), .trig_en(trig_en),
    .tx_sel(tx_baud_sel), .rx_sel(rx_baud_sel),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .hold_wr(hold_wr), .hold_wdata(hold_wdata),
    .ovf_clr(ovf_clr), .ext_clr(ext_clr),
    .count_q(count), .hold_q(hold), .ovf_q(ovf_flag), .ext_q(ext_flag),
    .tx_q(tx_tick), .rx_q(rx_tick)
  );

  // R11
  tx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |-> $past(tx_baud_sel));
  // R11
  rx_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tick |-> $past(rx_baud_sel));
endmodule

// File: tb/capreload_timer_bench.sv
`timescale 1ns/1ps
module capreload_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, src_ext = 1'b0, cap_mode = 1'b0;
  logic        rx_baud_sel = 1'b0, tx_baud_sel = 1'b0, trig_en = 1'b0;
  logic        count_pin = 1'b1, trig_pin = 1'b1;
  logic        cnt_wr = 1'b0, hold_wr = 1'b0, ovf_clr = 1'b0, ext_clr = 1'b0;
  logic [15:0] cnt_wdata = '0, hold_wdata = '0;
  logic [15:0] count, hold;
  logic        ovf_flag, ext_flag, tx_tick, rx_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  capreload_timer u_capreload_timer (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_ext(src_ext),
    .cap_mode(cap_mode), .rx_baud_sel(rx_baud_sel), .tx_baud_sel(tx_baud_sel),
    .trig_en(trig_en), .count_pin(count_pin), .trig_pin(trig_pin),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .hold_wr(hold_wr),
    .hold_wdata(hold_wdata), .ovf_clr(ovf_clr), .ext_clr(ext_clr),
    .count(count), .hold(hold), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
    .tx_tick(tx_tick), .rx_tick(rx_tick)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_count(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; wait_n(1); cnt_wr = 1'b0;
  endtask

  task automatic set_hold(input logic [15:0] v);
    hold_wr = 1'b1; hold_wdata = v; wait_n(1); hold_wr = 1'b0;
  endtask

  task automatic clear_flags();
    ovf_clr = 1'b1; ext_clr = 1'b1; wait_n(1); ovf_clr = 1'b0; ext_clr = 1'b0;
  endtask

  task automatic pulse_cnt();
    count_pin = 1'b0; wait_n(1); count_pin = 1'b1; wait_n(3);
  endtask

  task automatic pulse_trig();
    trig_pin = 1'b0; wait_n(1); trig_pin = 1'b1; wait_n(3);
  endtask

  task automatic set_mode(input logic rx, input logic tx, input logic cap);
    rx_baud_sel = rx; tx_baud_sel = tx; cap_mode = cap;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] start;
    int ticks;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    check("R1 count", 32'(count), 32'h0);
    check("R1 hold", 32'(hold), 32'h0);
    check("R1 flags", {30'h0, ovf_flag, ext_flag}, 32'h0);
    check("R1 ticks", {30'h0, tx_tick, rx_tick}, 32'h0);

    // R13 software writes
    set_count(16'h5A5A);
    check("R13 count write", 32'(count), 32'h5A5A);
    set_hold(16'hC3C3);
    check("R13 hold write", 32'(hold), 32'hC3C3);

    // R2 internal divider sweep, reload mode then baud mode
    for (int b = 0; b < 2; b++) begin
      for (int n = 1; n <= 5; n++) begin
        int div;
        div = (b == 1) ? 2 : 12;
        set_mode(1'b0, b[0], 1'b0);
        run_en = 1'b0;
        set_count(16'h0000);
        run_en = 1'b1;
        wait_n(div * n - 1);
        check("R2 before step", 32'(count), 32'(n - 1));
        wait_n(1);
        check("R2 after step", 32'(count), 32'(n));
      end
    end

    // R4 idle hold
    run_en = 1'b0;
    start = count;
    wait_n(30);
    check("R4 hold while stopped", 32'(count), 32'(start));

    // R3 external count pin, latency and sweep
    set_mode(1'b0, 1'b0, 1'b0);
    src_ext = 1'b1;
    run_en = 1'b1;
    set_count(16'h0100);
    count_pin = 1'b0;
    wait_n(2);
    check("R3 not yet", 32'(count), 32'h0100);
    wait_n(1);
    check("R3 third edge", 32'(count), 32'h0101);
    count_pin = 1'b1;
    wait_n(2);
    for (int k = 0; k < 10; k++) pulse_cnt();
    check("R3 ten pulses", 32'(count), 32'h010B);

    // R5 reload on overflow, sweep of holding values
    for (int i = 0; i < 16; i++) begin
      logic [15:0] rv;
      rv = 16'(i * 16'h1111 + 3);
      clear_flags();
      set_hold(rv);
      set_count(16'hFFFE);
      pulse_cnt();
      check("R5 pre-wrap", 32'(count), 32'hFFFF);
      check("R5 no flag yet", {31'h0, ovf_flag}, 32'h0);
      pulse_cnt();
      check("R5 reloaded", 32'(count), 32'(rv));
      check("R5 flag", {31'h0, ovf_flag}, 32'h1);
    end

    // R12 flag holds, then clears
    wait_n(10);
    check("R12 ovf held", {31'h0, ovf_flag}, 32'h1);
    ovf_clr = 1'b1; wait_n(1); ovf_clr = 1'b0;
    check("R12 ovf cleared", {31'h0, ovf_flag}, 32'h0);

    // R6 capture mode wraps to zero
    set_mode(1'b0, 1'b0, 1'b1);
    set_hold(16'h7777);
    set_count(16'hFFFF);
    pulse_cnt();
    check("R6 wrap to zero", 32'(count), 32'h0);
    check("R6 flag", {31'h0, ovf_flag}, 32'h1);
    check("R6 hold untouched", 32'(hold), 32'h7777);
    clear_flags();

    // R7 / R10 capture on trigger, latency
    trig_en = 1'b1;
    set_count(16'h1234);
    trig_pin = 1'b0;
    wait_n(2);
    check("R10 not yet", {31'h0, ext_flag}, 32'h0);
    check("R7 not yet", 32'(hold), 32'h7777);
    wait_n(1);
    check("R10 ext set", {31'h0, ext_flag}, 32'h1);
    check("R7 captured", 32'(hold), 32'h1234);
    check("R7 count kept", 32'(count), 32'h1234);
    trig_pin = 1'b1;
    wait_n(2);
    pulse_cnt();
    check("R7 counting continues", 32'(count), 32'h1235);
    check("R7 hold stable", 32'(hold), 32'h1234);
    // R12 ext flag clear
    check("R12 ext held", {31'h0, ext_flag}, 32'h1);
    ext_clr = 1'b1; wait_n(1); ext_clr = 1'b0;
    check("R12 ext cleared", {31'h0, ext_flag}, 32'h0);

    // R8 reload on trigger
    set_mode(1'b0, 1'b0, 1'b0);
    set_hold(16'hABCD);
    set_count(16'h0042);
    pulse_trig();
    check("R8 reloaded", 32'(count), 32'hABCD);
    check("R8 hold unchanged", 32'(hold), 32'hABCD);
    check("R10 ext in reload", {31'h0, ext_flag}, 32'h1);
    clear_flags();

    // R9 trigger disabled: reload mode and capture mode
    trig_en = 1'b0;
    set_count(16'h0011);
    pulse_trig();
    check("R9 no reload", 32'(count), 32'h0011);
    check("R9 no flag", {31'h0, ext_flag}, 32'h0);
    set_mode(1'b0, 1'b0, 1'b1);
    pulse_trig();
    check("R9 no capture", 32'(hold), 32'hABCD);
    check("R9 no flag capture", {31'h0, ext_flag}, 32'h0);

    // R11 baud mode, stepped externally; cap_mode ignored
    for (int s = 1; s < 4; s++) begin
      set_mode(s[0], s[1], 1'b1);
      clear_flags();
      set_hold(16'hFFFE);
      set_count(16'hFFFF);
      count_pin = 1'b0;
      wait_n(3);
      check("R11 reload", 32'(count), 32'hFFFE);
      check("R11 tx tick", {31'h0, tx_tick}, 32'(s[1]));
      check("R11 rx tick", {31'h0, rx_tick}, 32'(s[0]));
      check("R11 no ovf", {31'h0, ovf_flag}, 32'h0);
      wait_n(1);
      check("R11 tick one cycle", {30'h0, tx_tick, rx_tick}, 32'h0);
      count_pin = 1'b1;
      wait_n(2);
    end

    // R11 trigger in baud mode: flag only
    trig_en = 1'b1;
    set_mode(1'b0, 1'b1, 1'b1);
    set_hold(16'h2222);
    set_count(16'h3333);
    pulse_trig();
    check("R11 no capture", 32'(hold), 32'h2222);
    check("R11 no trig reload", 32'(count), 32'h3333);
    check("R10 ext in baud", {31'h0, ext_flag}, 32'h1);
    set_mode(1'b0, 1'b1, 1'b0);
    pulse_trig();
    check("R11 no reload cap0", 32'(count), 32'h3333);

    // R11 / R2 internal baud rate: tick every 2 steps of 2 cycles
    src_ext = 1'b0;
    set_hold(16'hFFFE);
    set_count(16'hFFFE);
    ticks = 0;
    for (int c = 0; c < 40; c++) begin
      wait_n(1);
      if (tx_tick) ticks++;
    end
    check("R11 internal tick rate", 32'(ticks), 32'd10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule